// File: doc/BRIEF.md
# Swizzled 64 KiB Tile Address Generator

This block turns a pixel coordinate on a surface into the byte address of that pixel in a buffer stored as 64 KiB swizzled tiles. The caller gives the bytes per element, the x and y coordinates and the surface width in pixels. The block finds the size-class index, the tile width and height, and the number of tiles in one row of the surface. It then forms the tile index and builds the 16-bit byte offset inside the tile. Each offset bit is a single x or y coordinate bit, picked by a fixed bit-class map and by a per-size position table.

The work is split over two register stages. Stage one holds the tile geometry and the swizzled offset. Stage two holds the multiply-add that turns the tile row and column into a tile index. A new coordinate can enter on every cycle, and each result comes out two cycles after its input.

Top module: `swz_tile_addr_gen`

## Requirements
- R1: The size index is the ceiling of log2 of `in_bpe`. Values 0 and 1 give 0, 2 gives 1, 3 to 4 give 2, 5 to 8 give 3, and 9 to 16 give 4. Any larger value is clamped to 4.
- R2: Tile width by height in pixels for size index 0 to 4 is 256x256, 256x128, 128x128, 128x64 and 64x64.
- R3: The number of tiles per row is `in_width` divided by the tile width, rounded up. A width that is an exact multiple of the tile width adds no extra tile. The tile index is (y / tile height) * tiles per row + (x / tile width), with truncating division.
- R4: Offset bits 0 and 1 are always zero, so every address is a multiple of 4.
- R5: Let xs = x << size index, and let L = T[size index][bit]. Offset bits 2, 3, 7, 9, 11, 13 and 15 take bit L+2 of xs. Offset bits 4, 5, 6, 8, 10, 12 and 14 take bit L of y. The rows of T, listed for bit 0 to 15, are: index 0 {0,1,2,3,0,1,2,3,4,4,5,5,6,6,7,7}, index 1 {0,0,1,2,0,1,2,3,3,4,4,5,5,6,6,7}, index 2 {0,0,0,1,0,1,2,2,3,3,4,4,5,5,6,6}, index 3 {0,0,0,0,0,1,1,2,2,3,3,4,4,5,5,6}, index 4 {0,0,0,0,0,1,0,1,2,2,3,3,4,4,5,5}.
- R6: `out_addr` equals tile index * 65536 + offset, truncated to AW bits.
- R7: `out_valid` goes high exactly two clock cycles after a cycle in which `in_valid` is high, and `out_addr` is the result for that input. Inputs presented on consecutive cycles give results on consecutive cycles. Cycles with `in_valid` low give no result.
- R8: While `rst_n` is low, `out_valid` is low. After reset is released, `out_valid` stays low until an input is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Coordinate present this cycle |
| in_bpe | input | 5 | Bytes per element |
| in_x | input | CW | Pixel column |
| in_y | input | CW | Pixel row |
| in_width | input | CW | Surface width in pixels |
| out_valid | output | 1 | Address present this cycle |
| out_addr | output | AW | Byte address within the tiled buffer |

## Verification
The assertions check the following properties on every cycle:
- the valid bit travels through both stages without being lost or invented;
- addresses stay 4-byte aligned;
- a four-byte element selects size index 2;
- an in-range column never lands at or beyond the tiles-per-row count.

Only the bench's scenarios can show that the swizzle positions, the tile dimensions, the rounded-up pitch and the final multiply-add give the right numbers. The bench compares against an independent model at tile edges, at exact-multiple widths, at every element size and at random points.

// File: rtl/tile_addr_pkg.sv
package tile_addr_pkg;
  localparam int unsigned NUM_SIZES = 5;
  localparam int unsigned OFF_BITS  = 16;

  typedef logic [2:0] size_idx_t;

  // bit class per offset bit: 0 zero, 1 from shifted x, 2 from y
  localparam int unsigned BIT_CLASS [OFF_BITS] =
    '{0,0,1,1,2,2,2,1,2,1,2,1,2,1,2,1};

  // coordinate-bit position base per size index and offset bit
  localparam int unsigned SEL_POS [NUM_SIZES][OFF_BITS] = '{
    '{0,1,2,3,0,1,2,3,4,4,5,5,6,6,7,7},
    '{0,0,1,2,0,1,2,3,3,4,4,5,5,6,6,7},
    '{0,0,0,1,0,1,2,2,3,3,4,4,5,5,6,6},
    '{0,0,0,0,0,1,1,2,2,3,3,4,4,5,5,6},
    '{0,0,0,0,0,1,0,1,2,2,3,3,4,4,5,5}
  };

  // log2 of tile width and height in pixels per size index
  localparam int unsigned TW_LOG [NUM_SIZES] = '{8,8,7,7,6};
  localparam int unsigned TH_LOG [NUM_SIZES] = '{8,7,7,6,6};

  // ceiling log2 of the element byte count, clamped to the last size
  function automatic size_idx_t size_of_bytes(input logic [4:0] nbytes);
    if (nbytes <= 5'd1)      return 3'd0;
    else if (nbytes == 5'd2) return 3'd1;
    else if (nbytes <= 5'd4) return 3'd2;
    else if (nbytes <= 5'd8) return 3'd3;
    else                     return 3'd4;
  endfunction
endpackage

// File: rtl/tile_geom.sv
module tile_geom
  import tile_addr_pkg::*;
#(
  parameter int unsigned CW = 14
) (
  input  logic [4:0]    bpe,
  input  logic [CW-1:0] x,
  input  logic [CW-1:0] y,
  input  logic [CW-1:0] width,
  output size_idx_t     idx,
  output logic [CW-1:0] col,
  output logic [CW-1:0] row,
  output logic [CW:0]   per_row
);
  logic [3:0] lw, lh;

  function automatic logic [CW:0] ceil_shift(input logic [CW-1:0] v,
                                             input logic [3:0] sh);
    logic [CW:0] round;
    round = ((CW+1)'(1) << sh) - (CW+1)'(1);
    return ((CW+1)'(v) + round) >> sh;
  endfunction

  always_comb begin
    idx     = size_of_bytes(bpe);
    lw      = 4'(TW_LOG[idx]);
    lh      = 4'(TH_LOG[idx]);
    col     = x >> lw;
    row     = y >> lh;
    per_row = ceil_shift(width, lw);
  end
endmodule

// File: rtl/tile_swizzle.sv
module tile_swizzle
  import tile_addr_pkg::*;
#(
  parameter int unsigned CW = 14
) (
  input  size_idx_t       idx,
  input  logic [CW-1:0]   x,
  input  logic [CW-1:0]   y,
  output logic [OFF_BITS-1:0] off
);
  logic [CW+3:0] xs;
  assign xs = (CW+4)'(x) << idx;

  for (genvar b = 0; b < OFF_BITS; b++) begin : g_bit
    if (BIT_CLASS[b] == 0) begin : g_zero
      assign off[b] = 1'b0;
    end else if (BIT_CLASS[b] == 1) begin : g_xbit
      logic [3:0] pos;
      assign pos    = 4'(SEL_POS[idx][b] + 2);
      assign off[b] = xs[pos];
    end else begin : g_ybit
      logic [3:0] pos;
      assign pos    = 4'(SEL_POS[idx][b]);
      assign off[b] = y[pos];
    end
  end
endmodule

// File: rtl/swz_tile_addr_gen.sv
module swz_tile_addr_gen
  import tile_addr_pkg::*;
#(
  parameter int unsigned CW = 14,
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [4:0]    in_bpe,
  input  logic [CW-1:0] in_x,
  input  logic [CW-1:0] in_y,
  input  logic [CW-1:0] in_width,
  output logic          out_valid,
  output logic [AW-1:0] out_addr
);
  localparam int unsigned BW = 2*CW + 2;

  size_idx_t           g_idx;
  logic [CW-1:0]       g_col, g_row;
  logic [CW:0]         g_per_row;
  logic [OFF_BITS-1:0] g_off;

  tile_geom #(.CW(CW)) geom_i (
    .bpe(in_bpe), .x(in_x), .y(in_y), .width(in_width),
    .idx(g_idx), .col(g_col), .row(g_row), .per_row(g_per_row)
  );

  tile_swizzle #(.CW(CW)) swz_i (
    .idx(g_idx), .x(in_x), .y(in_y), .off(g_off)
  );

  logic                s1_valid;
  size_idx_t           s1_idx;
  logic [CW-1:0]       s1_col, s1_row;
  logic [CW:0]         s1_per_row;
  logic [OFF_BITS-1:0] s1_off;
  logic [BW-1:0]       tile_num;
  logic [AW-1:0]       addr_next;

  assign tile_num  = BW'(s1_row) * BW'(s1_per_row) + BW'(s1_col);
  assign addr_next = AW'({tile_num, s1_off});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid   <= 1'b0;
      s1_idx     <= '0;
      s1_col     <= '0;
      s1_row     <= '0;
      s1_per_row <= '0;
      s1_off     <= '0;
      out_valid  <= 1'b0;
      out_addr   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_idx     <= g_idx;
        s1_col     <= g_col;
        s1_row     <= g_row;
        s1_per_row <= g_per_row;
        s1_off     <= g_off;
      end
      out_valid <= s1_valid;
      if (s1_valid) out_addr <= addr_next;
    end
  end

  // R7: accepted input reaches stage one, stage one reaches the output
  p_stage1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);
  p_stage2_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);
  p_no_phantom_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid);
  // R4: addresses are always 4-byte aligned
  p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_addr[1:0] == 2'b00);
  // R1: four bytes per element selects size index 2
  p_four_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_bpe == 5'd4) |=> s1_idx == 3'd2);
  // R3: an in-range column stays below the tiles-per-row count
  p_col_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_x < in_width) |=> s1_col < s1_per_row);
endmodule

// File: tb/swz_tile_addr_gen_tb.sv
module swz_tile_addr_gen_tb_top;
  localparam int CW = 14;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [4:0]    in_bpe = '0;
  logic [CW-1:0] in_x = '0, in_y = '0, in_width = '0;
  logic          out_valid;
  logic [AW-1:0] out_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  longint unsigned exp_q[$];
  string           tag_q[$];

  always #2 clk = ~clk;

  swz_tile_addr_gen #(.CW(CW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bpe(in_bpe),
    .in_x(in_x), .in_y(in_y), .in_width(in_width),
    .out_valid(out_valid), .out_addr(out_addr)
  );

  // bench-side pattern values (powers of two, 0 = unused)
  int pat [5][16] = '{
    '{1,2,4,8, 1,2,4,8,16,16,32,32,64,64,128,128},
    '{0,1,2,4, 1,2,4,8,8,16,16,32,32,64,64,128},
    '{0,0,1,2, 1,2,4,4,8,8,16,16,32,32,64,64},
    '{0,0,0,1, 1,2,2,4,4,8,8,16,16,32,32,64},
    '{0,0,0,0, 1,2,1,2,4,4,8,8,16,16,32,32}
  };
  int chan [16] = '{0,0,1,1,2,2,2,1,2,1,2,1,2,1,2,1};

  function automatic longint unsigned model(int bpe, int x, int y, int w);
    int e, k, bw, bh, tw, th, tpr, blk, xs, off, p, lg, bitv;
    e = bpe; k = 0;
    while (e > 1) begin k++; e = (e + 1) >> 1; end
    if (k > 4) k = 4;
    case (k)
      0: begin bw = 16; bh = 16; end
      1: begin bw = 16; bh = 8;  end
      2: begin bw = 8;  bh = 8;  end
      3: begin bw = 8;  bh = 4;  end
      default: begin bw = 4; bh = 4; end
    endcase
    tw = bw * 16; th = bh * 16;
    tpr = ((w + tw - 1) / tw * tw) / tw;
    blk = (y / th) * tpr + x / tw;
    xs = x << k;
    off = 0;
    for (int i = 0; i < 16; i++) begin
      p = pat[k][i]; lg = 0;
      while (p > 1) begin lg++; p = (p + 1) >> 1; end
      if (chan[i] == 1)      bitv = (xs >> (lg + 2)) & 1;
      else if (chan[i] == 2) bitv = (y >> lg) & 1;
      else                   bitv = 0;
      off = off | (bitv << i);
    end
    return ((longint'(blk) << 16) + off) & 64'hFFFF_FFFF;
  endfunction

  task automatic check(bit ok, string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(int bpe, int x, int y, int w, longint unsigned exp, string tag);
    @(negedge clk);
    in_valid = 1'b1; in_bpe = 5'(bpe);
    in_x = CW'(x); in_y = CW'(y); in_width = CW'(w);
    exp_q.push_back(exp); tag_q.push_back(tag);
  endtask

  task automatic send_m(int bpe, int x, int y, int w, string tag);
    send(bpe, x, y, w, model(bpe, x, y, w), tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R7 unexpected result", out_addr, 0);
      end else begin
        longint unsigned e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(out_addr == e[AW-1:0], t, out_addr, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    // R8: reset
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8 in reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8 after reset", out_valid, 0);

    // R7: two-cycle latency of a single item (hand value: R5 bit2/bit4 -> 20)
    send(4, 1, 1, 128, 64'd20, "R5 R7 single");
    @(negedge clk); in_valid = 1'b0;
    check(out_valid == 1'b0, "R7 not yet", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R7 latency", out_valid, 1);
    repeat (3) idle();

    // hand-computed values
    send(4, 128, 0, 256, 64'h10000, "R3 R6 second tile");
    send(1, 0, 0, 1, 64'd0, "R4 origin");
    send(4, 127, 0, 128, model(4, 127, 0, 128), "R3 last column");
    idle(); idle(); idle();

    // R1/R2: every byte count, including clamp values
    for (int b = 0; b <= 20; b++) begin
      send_m(b, 300, 200, 1000, "R1 size sweep");
      send_m(b, 63, 63, 64, "R2 edge lower");
      send_m(b, 64, 64, 65, "R2 edge upper");
      send_m(b, 255, 255, 512, "R2 large tile edge");
      send_m(b, 256, 128, 513, "R2 tile step");
    end
    // R3: exact-multiple widths vs one more pixel
    for (int k = 1; k <= 16; k *= 2) begin
      send_m(k, 0, 700, 256, "R3 exact width");
      send_m(k, 0, 700, 257, "R3 one over");
      send_m(k, 5, 300, 1, "R3 width one");
    end
    idle();
    // R5/R6: back-to-back random points
    for (int i = 0; i < 400; i++) begin
      int w, x, y, b;
      w = $urandom_range(16383, 1);
      x = $urandom_range(w - 1, 0);
      y = $urandom_range(16383, 0);
      b = 1 << $urandom_range(4, 0);
      send_m(b, x, y, w, "R5 R6 random");
      if ((i % 37) == 0) idle();
    end
    repeat (4) idle();
    check(exp_q.size() == 0, "R7 all results seen", exp_q.size(), 0);
    finish_run();
  end
endmodule